// File: doc/BRIEF.md
# Fifth-Order Decimating Filter for a One-Bit Modulator Stream

This block turns the single-bit output of a delta-sigma modulator into 20-bit conversion results. A prescaler divides the system clock by 6 to make a modulator-rate enable. Each enabled cycle feeds one modulator bit, read as +1 for a logic 1 and -1 for a logic 0, into a chain of five integrators. A chain of five differentiators runs once every 64 modulator samples. Together these give a fifth-order box-car response, normalised to unity DC gain, with a decimation ratio of 64. A new result therefore appears every 384 system clocks, and the output rate follows the system clock directly.

With each result the block raises a strobe for one cycle. It also keeps a settled flag that tells the consumer when enough full conversions have passed since reset, or since an input step that an outside agent flagged, for the filter window to hold only post-step data. A step flagged in the same cycle as the strobe needs five further conversions. A step flagged at any other time needs six.

Top module: `sinc5_decim`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, result_o is 0, dready_o is 0 and settled_o is 0.
- R2: dready_o first goes high after the 384th rising clock edge following reset release. It goes high again every 384 clocks after that.
- R3: dready_o is high for exactly one clock cycle per result.
- R4: result_o changes only in a cycle in which dready_o is high.
- R5: result_o is a 20-bit two's-complement code equal to the filtered mean of the bitstream times 2^19, with 1 mapped to +1 and 0 mapped to -1. Once a periodic pattern whose period divides 64 has run long enough, the code is exact. An all-zero input gives 0x80000. The pattern 1,1,0,0 gives 0x00000. The pattern 1,1,1,0 gives 0x40000. The pattern 1,0,0,0 gives 0xC0000. Seven ones followed by one zero gives 0x60000. The pattern 1,0 gives 0x00000.
- R6: A constant all-ones input gives 0x7FFFF. Positive full scale clamps to the largest code and does not wrap.
- R7: After reset, settled_o rises in the cycle after the 6th dready_o strobe. It rises only in the cycle after a strobe. It stays high until the next step_i pulse or reset.
- R8: A step_i pulse in a cycle where dready_o is low clears settled_o in the next cycle. settled_o then rises again after the 6th strobe that follows.
- R9: A step_i pulse in the same cycle as a dready_o strobe clears settled_o. settled_o then rises again after the 5th strobe that follows.
- R10: step_i has no effect on the filter data. Results after a step pulse keep the value that the bitstream alone sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_bit_i | input | 1 | Modulator bitstream, sampled once per 6 clocks |
| step_i | input | 1 | One-cycle pulse flagging an input step |
| result_o | output | 20 | Decimated conversion result, two's complement |
| dready_o | output | 1 | One-cycle strobe with each new result |
| settled_o | output | 1 | High once the filter window holds only post-step data |

## Verification
The hardest case to reach from the ports is a step pulse that lands exactly in the strobe cycle, because that is the only case that loads the shorter settling count. The bench finds it by stopping on the sample point where the strobe is seen and raising step_i there, so the next clock edge sees both signals together. A second pulse raised well away from any strobe covers the longer count. Exact expected codes come from periodic patterns whose period divides 64: every window sum is constant for these patterns, so the settled result does not depend on where the pattern starts.

// File: rtl/sinc5_pkg.sv
package sinc5_pkg;
  localparam int unsigned SETTLE_ASYNC   = 6;
  localparam int unsigned SETTLE_ALIGNED = 5;

  // bits of a full-scale comb output: sign + order*log2(decim)
  function automatic int unsigned res_width(int unsigned order, int unsigned decim);
    return 1 + order * $clog2(decim);
  endfunction
endpackage

// File: rtl/sinc5_rate.sv
module sinc5_rate #(
  parameter int unsigned PRESCALE = 6,
  parameter int unsigned DECIM    = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mod_en_o,
  output logic tick_o
);
  localparam int unsigned PW = $clog2(PRESCALE);
  localparam int unsigned DW = $clog2(DECIM);

  logic [PW-1:0] pre_q;
  logic [DW-1:0] dec_q;

  assign mod_en_o = (pre_q == PW'(PRESCALE - 1));
  assign tick_o   = mod_en_o && (dec_q == DW'(DECIM - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      dec_q <= '0;
    end else begin
      pre_q <= mod_en_o ? '0 : pre_q + PW'(1);
      if (mod_en_o) dec_q <= tick_o ? '0 : dec_q + DW'(1);
    end
  end
endmodule

// File: rtl/sinc5_integ.sv
module sinc5_integ #(
  parameter int unsigned ORDER = 5,
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_w [ORDER];

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    logic [ACC_W-1:0] inc;
    logic [ACC_W-1:0] acc_q;
    if (s == 0) begin : g_in
      assign inc = bit_i ? ACC_W'(1) : '1;  // +1 / -1
    end else begin : g_chain
      assign inc = acc_w[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   acc_q <= '0;
      else if (en_i) acc_q <= acc_q + inc;  // wraps by design
    end
    assign acc_w[s] = acc_q;
  end

  assign acc_o = acc_w[ORDER-1];
endmodule

// File: rtl/sinc5_comb.sv
module sinc5_comb #(
  parameter int unsigned ORDER = 5,
  parameter int unsigned ACC_W = 32,
  parameter int unsigned RES_W = 31,
  parameter int unsigned OUT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [OUT_W-1:0] result_o,
  output logic             vld_o
);
  localparam logic [ACC_W-1:0] MAXV = ACC_W'((64'd1 << (RES_W - 1)) - 64'd1);

  logic [ACC_W-1:0] diff [ORDER+1];
  logic [ACC_W-1:0] clamp;
  logic [OUT_W-1:0] res_q;
  logic             vld_q;

  assign diff[0] = acc_i;

  for (genvar s = 0; s < ORDER; s++) begin : g_stage
    logic [ACC_W-1:0] dly_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dly_q <= '0;
      else if (tick_i) dly_q <= diff[s];
    end
    assign diff[s+1] = diff[s] - dly_q;
  end

  // only +full scale can exceed RES_W bits
  assign clamp = ($signed(diff[ORDER]) > $signed(MAXV)) ? MAXV : diff[ORDER];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= tick_i;
      if (tick_i) res_q <= clamp[RES_W-1 -: OUT_W];
    end
  end

  assign result_o = res_q;
  assign vld_o    = vld_q;
endmodule

// File: rtl/sinc5_settle.sv
module sinc5_settle #(
  parameter int unsigned ASYNC_CNT   = 6,
  parameter int unsigned ALIGNED_CNT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic step_i,
  output logic settled_o
);
  localparam int unsigned CW = $clog2(ASYNC_CNT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= CW'(ASYNC_CNT);
    else if (step_i)                    cnt_q <= strobe_i ? CW'(ALIGNED_CNT) : CW'(ASYNC_CNT);
    else if (strobe_i && cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign settled_o = (cnt_q == '0);
endmodule

// File: rtl/sinc5_decim.sv
module sinc5_decim #(
  parameter int unsigned PRESCALE = 6,
  parameter int unsigned DECIM    = 64,
  parameter int unsigned ORDER    = 5,
  parameter int unsigned OUT_W    = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mod_bit_i,
  input  logic             step_i,
  output logic [OUT_W-1:0] result_o,
  output logic             dready_o,
  output logic             settled_o
);
  localparam int unsigned RES_W = sinc5_pkg::res_width(ORDER, DECIM);
  localparam int unsigned ACC_W = RES_W + 1;  // one guard bit for +full scale

  logic             mod_en;
  logic             tick;
  logic [ACC_W-1:0] acc;

  sinc5_rate #(.PRESCALE(PRESCALE), .DECIM(DECIM)) u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .mod_en_o(mod_en), .tick_o(tick)
  );

  sinc5_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(mod_en), .bit_i(mod_bit_i), .acc_o(acc)
  );

  sinc5_comb #(.ORDER(ORDER), .ACC_W(ACC_W), .RES_W(RES_W), .OUT_W(OUT_W)) u_comb (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .acc_i(acc),
    .result_o(result_o), .vld_o(dready_o)
  );

  sinc5_settle #(
    .ASYNC_CNT(sinc5_pkg::SETTLE_ASYNC), .ALIGNED_CNT(sinc5_pkg::SETTLE_ALIGNED)
  ) u_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(dready_o), .step_i(step_i),
    .settled_o(settled_o)
  );
endmodule

// File: rtl/sinc5_decim_chk.sv
module sinc5_decim_chk #(
  parameter int unsigned PERIOD = 384,
  parameter int unsigned OUT_W  = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step_i,
  input logic [OUT_W-1:0] result_o,
  input logic             dready_o,
  input logic             settled_o
);
  localparam int unsigned GW = $clog2(PERIOD + 1) + 1;

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_q <= '0;
    else if (dready_o)    gap_q <= GW'(1);
    else if (gap_q != '1) gap_q <= gap_q + GW'(1);
  end

  AST_STROBE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dready_o |-> gap_q == GW'(PERIOD));  // R2

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dready_o |=> !dready_o);  // R3

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dready_o |-> $stable(result_o));  // R4

  AST_SETTLE_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(settled_o) |-> $past(dready_o));  // R7

  AST_SETTLE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled_o && !step_i |=> settled_o);  // R7

  AST_STEP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> !settled_o);  // R8
endmodule

bind sinc5_decim sinc5_decim_chk #(.PERIOD(PRESCALE * DECIM), .OUT_W(OUT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .result_o(result_o),
  .dready_o(dready_o), .settled_o(settled_o)
);

// File: tb/sim_sinc5_decim.sv
module sim_sinc5_decim;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_bit = 1'b0;
  logic        step = 1'b0;
  logic [19:0] result;
  logic        dready;
  logic        settled;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] pat = 8'h00;
  int         plen = 1;

  // pattern[31:24] (bit0 first), length[23:20], expected code[19:0]
  localparam int NV = 7;
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 4'd1, 20'h80000},   // R5 all zeros
    {8'h01, 4'd1, 20'h7FFFF},   // R6 all ones clamps
    {8'h03, 4'd4, 20'h00000},   // R5 1100
    {8'h01, 4'd4, 20'hC0000},   // R5 1000
    {8'h7F, 4'd8, 20'h60000},   // R5 1111_1110
    {8'h01, 4'd2, 20'h00000},   // R5 10
    {8'h07, 4'd4, 20'h40000}    // R5 1110, kept for step tests
  };

  sinc5_decim u0 (
    .clk_i(clk), .rst_ni(rst_n), .mod_bit_i(mod_bit), .step_i(step),
    .result_o(result), .dready_o(dready), .settled_o(settled)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_strobe();
    @(negedge clk);
    while (!dready) @(negedge clk);
  endtask

  // one modulator bit per 6 clocks, aligned to reset release
  initial begin
    int idx = 0;
    wait (rst_n);
    forever begin
      mod_bit = pat[idx % plen];
      repeat (6) @(negedge clk);
      idx++;
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(result == 0 && !dready && !settled, "R1 in reset",
          {11'd0, result, dready}, 0);
    rst_n = 1'b1;  // at negedge
    @(negedge clk);
    n = 1;
    check(result == 0 && !dready && !settled, "R1 after release",
          {11'd0, result, dready}, 0);
    while (!dready) begin @(negedge clk); n++; end
    check(n == 384, "R2 first strobe", n, 384);
    check(!settled, "R7 strobe1", settled, 0);
    @(negedge clk);
    check(!dready, "R3 width", dready, 0);
    n = 1;
    while (!dready) begin @(negedge clk); n++; end
    check(n == 384, "R2 interval", n, 384);
    for (int k = 3; k <= 6; k++) begin
      wait_strobe();
      check(!settled, "R7 before 6th", settled, 0);
    end
    @(negedge clk);
    check(settled, "R7 after 6th", settled, 1);

    // vector table
    for (int v = 0; v < NV; v++) begin
      pat  = VEC[v][31:24];
      plen = int'(VEC[v][23:20]);
      repeat (8) wait_strobe();
      for (int r = 0; r < 2; r++) begin
        wait_strobe();
        check(result == VEC[v][19:0], (v == 1) ? "R6 full scale" : "R5 level",
              result, VEC[v][19:0]);
      end
    end

    // step between strobes
    wait_strobe();
    repeat (100) @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    check(!settled, "R8 cleared", settled, 0);
    for (int k = 1; k <= 6; k++) begin
      wait_strobe();
      check(result == 20'h40000, "R10 data unaffected", result, 20'h40000);
      @(negedge clk);
      if (k < 6) check(!settled, "R8 still settling", settled, 0);
      else       check(settled, "R8 settled after 6", settled, 1);
    end

    // step coinciding with strobe
    wait_strobe();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    check(!settled, "R9 cleared", settled, 0);
    for (int k = 1; k <= 5; k++) begin
      wait_strobe();
      check(result == 20'h40000, "R10 data unaffected", result, 20'h40000);
      @(negedge clk);
      if (k < 5) check(!settled, "R9 still settling", settled, 0);
      else       check(settled, "R9 settled after 5", settled, 1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule